// File: doc/BRIEF.md
# Parallel Flash Command Mode Controller

This block is the control side of an asynchronous parallel flash bus, modelled as synchronous logic. It samples the chip-enable, output-enable and write-enable strobes and a separate active-low bus reset on every clock. It turns completed bus writes into command steps and picks the byte shown on the 8-bit read port. That byte is array contents, an identification or sector-protect code, a busy status byte, or nothing with the enable low. A small internal RAM stands in for the cell array. A start pulse with the target address and data goes to an external program engine, and the engine answers through a busy input.

Commands begin with two unlock writes. A third write picks the action: enter identification mode, arm a program, or return to array read. Any write that breaks the expected pattern drops the controller back to array read. A bus reset that stays low long enough aborts any program in progress and clears every mode. For as long as the reset is low, the bus is ignored.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After `rst_ni` and after any valid bus reset the controller is in array-read mode, so a read returns RAM contents with no command written first.
- R2: A read cycle needs `ce_ni`=0, `oe_ni`=0 and `we_ni`=1, and `data_oe_o` rises two clocks after that pattern is applied. If `ce_ni` is high or `we_ni` is low, nothing is driven.
- R3: A write is taken when `ce_ni` and `we_ni` were low with `oe_ni` high, and then `we_ni` or `ce_ni` rises, whichever comes first. Address and data are those sampled just before the rise. A low-strobe phase with `oe_ni` low is not a write.
- R4: A wrong address or data value at any unlock or select step clears the sequence and forces array-read mode.
- R5: The writes 0xAA@0x555, 0x55@0x2AA, 0x90@0x555 select identification mode. Reads then return values by `addr_i[1:0]`: 0 gives MFR_CODE, 1 gives DEV_CODE, 2 gives {7'b0, PROT_MAP[s]} where s is the top log2(SECTORS) address bits, and 3 gives 0.
- R6: The read mode persists across any number of reads until another command write arrives.
- R7: Writing 0xF0 to any address, while idle or part-way through an unlock, returns to array-read mode.
- R8: The writes 0xAA@0x555, 0x55@0x2AA, 0xA0@0x555, then D@A store D at RAM address A. They also pulse `pgm_start_o` for one clock with `pgm_addr_o`=A and `pgm_data_o`=D.
- R9: From the program start until `busy_i` falls, reads return {~D[7], 7'b0} and command writes are ignored. While `busy_i` is high, writes are also ignored.
- R10: With `oe_ni` high, `data_oe_o` is 0. Whenever `data_oe_o` is 0, `data_o` is 0.
- R11: While `flash_rst_ni` is low, no byte is driven and bus cycles are ignored. Once it has been low for RST_MIN sampled clocks, `pgm_abort_o` pulses once, the busy status clears and the mode returns to array read.
- R12: A `flash_rst_ni` low pulse shorter than RST_MIN clocks leaves the mode and sequence unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous power-on reset, active low |
| flash_rst_ni | input | 1 | Bus-side hardware reset, active low, filtered |
| ce_ni | input | 1 | Chip enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| we_ni | input | 1 | Write enable, active low |
| addr_i | input | AW | Word address |
| data_i | input | 8 | Write data |
| data_o | output | 8 | Read data |
| data_oe_o | output | 1 | Drive enable for data_o; low means high impedance |
| busy_i | input | 1 | Program engine busy |
| pgm_start_o | output | 1 | One-clock program start request |
| pgm_addr_o | output | AW | Program target address |
| pgm_data_o | output | 8 | Program data |
| pgm_abort_o | output | 1 | One-clock abort on a valid bus reset |

## Verification
The bench builds the block with RST_MIN=4, so that a 2-clock reset glitch and a 6-clock valid reset both fit in a few cycles. It sets PROT_MAP=4'b0101 so that neighbouring sectors give different protect bits. It uses distinct MFR_CODE and DEV_CODE values, and AW=11 so the unlock addresses fill the whole address. These values let the bench program bytes with bit 7 both set and clear, and check each status polarity. They also put identification reads, malformed sequences, writes ended by chip-enable, and resets arriving mid-program all within short directed runs.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PGM
  } seq_e;

  typedef enum logic {
    RD_ARRAY,
    RD_IDENT
  } rdmode_e;

  localparam int unsigned CMD_AW = 11;

  localparam logic [CMD_AW-1:0] UNL_ADDR_A = 11'h555;
  localparam logic [CMD_AW-1:0] UNL_ADDR_B = 11'h2AA;

  localparam logic [7:0] KEY_A     = 8'hAA;
  localparam logic [7:0] KEY_B     = 8'h55;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_PGM    = 8'hA0;
  localparam logic [7:0] OP_RETURN = 8'hF0;

endpackage

// File: rtl/fcc_bus_sampler.sv
module fcc_bus_sampler #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic          ce_q_o,
  output logic          oe_q_o,
  output logic          we_q_o,
  output logic [AW-1:0] addr_q_o,
  output logic          wr_evt_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o
);

  logic          ce_q, oe_q, we_q;
  logic          ce_p, oe_p, we_p;
  logic [AW-1:0] addr_q, addr_p;
  logic [7:0]    data_q, data_p;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ce_q   <= 1'b1;
      oe_q   <= 1'b1;
      we_q   <= 1'b1;
      ce_p   <= 1'b1;
      oe_p   <= 1'b1;
      we_p   <= 1'b1;
      addr_q <= '0;
      addr_p <= '0;
      data_q <= '0;
      data_p <= '0;
    end else begin
      ce_q   <= ce_ni;
      oe_q   <= oe_ni;
      we_q   <= we_ni;
      addr_q <= addr_i;
      data_q <= data_i;
      ce_p   <= ce_q;
      oe_p   <= oe_q;
      we_p   <= we_q;
      addr_p <= addr_q;
      data_p <= data_q;
    end
  end

  // write phase ends on the first of CE or WE rising
  assign wr_evt_o  = !ce_p && !we_p && oe_p && (ce_q || we_q);
  assign wr_addr_o = addr_p;
  assign wr_data_o = data_p;

  assign ce_q_o   = ce_q;
  assign oe_q_o   = oe_q;
  assign we_q_o   = we_q;
  assign addr_q_o = addr_q;

  a_r3_single_event: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_evt_o |=> !wr_evt_o)
    else $error("R3 write event lasted more than one clock");

endmodule

// File: rtl/fcc_reset_filter.sv
module fcc_reset_filter #(
  parameter int unsigned RST_MIN = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic flash_rst_ni,
  output logic blk_o,
  output logic valid_o
);

  localparam int unsigned CW = $clog2(RST_MIN + 1);
  localparam logic [CW-1:0] CNT_MAX  = CW'(RST_MIN);
  localparam logic [CW-1:0] CNT_LAST = CW'(RST_MIN - 1);

  logic          rst_q;
  logic [CW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_q   <= 1'b1;
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      rst_q   <= flash_rst_ni;
      valid_q <= !rst_q && (cnt_q == CNT_LAST);
      if (rst_q)
        cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign blk_o   = !rst_q;
  assign valid_o = valid_q;

  a_r11_abort_once: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o)
    else $error("R11 abort pulse longer than one clock");

  a_r12_needs_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(blk_o))
    else $error("R12 abort without reset held low");

endmodule

// File: rtl/fcc_array_ram.sv
module fcc_array_ram #(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);

  localparam int unsigned DEPTH = 1 << AW;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem[raddr_i];

endmodule

// File: rtl/fcc_cmd_fsm.sv
module fcc_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int unsigned AW = 11
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hw_rst_i,
  input  logic          wr_evt_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          busy_i,
  output logic          ident_o,
  output logic          stat_o,
  output logic          stat_b7_o,
  output logic          pgm_start_o,
  output logic [AW-1:0] pgm_addr_o,
  output logic [7:0]    pgm_data_o
);

  seq_e          seq_q;
  rdmode_e       mode_q;
  logic          stat_q, stat_b7_q, busy_d_q, start_q;
  logic [AW-1:0] paddr_q;
  logic [7:0]    pdata_q;
  logic          engaged, at_a, at_b;

  assign engaged = stat_q || busy_i;
  assign at_a    = wr_addr_i[CMD_AW-1:0] == UNL_ADDR_A;
  assign at_b    = wr_addr_i[CMD_AW-1:0] == UNL_ADDR_B;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seq_q     <= SEQ_IDLE;
      mode_q    <= RD_ARRAY;
      stat_q    <= 1'b0;
      stat_b7_q <= 1'b0;
      busy_d_q  <= 1'b0;
      start_q   <= 1'b0;
      paddr_q   <= '0;
      pdata_q   <= '0;
    end else begin
      start_q  <= 1'b0;
      busy_d_q <= busy_i;
      if (hw_rst_i) begin
        seq_q  <= SEQ_IDLE;
        mode_q <= RD_ARRAY;
        stat_q <= 1'b0;
      end else begin
        if (stat_q && busy_d_q && !busy_i) stat_q <= 1'b0;
        if (wr_evt_i && !engaged) begin
          unique case (seq_q)
            SEQ_IDLE: begin
              if (at_a && wr_data_i == KEY_A) seq_q <= SEQ_UNL1;
              else                            mode_q <= RD_ARRAY;
            end
            SEQ_UNL1: begin
              if (at_b && wr_data_i == KEY_B) begin
                seq_q <= SEQ_UNL2;
              end else begin
                seq_q  <= SEQ_IDLE;
                mode_q <= RD_ARRAY;
              end
            end
            SEQ_UNL2: begin
              seq_q <= SEQ_IDLE;
              if (at_a && wr_data_i == OP_IDENT)    mode_q <= RD_IDENT;
              else if (at_a && wr_data_i == OP_PGM) seq_q  <= SEQ_PGM;
              else                                  mode_q <= RD_ARRAY;
            end
            SEQ_PGM: begin
              seq_q     <= SEQ_IDLE;
              mode_q    <= RD_ARRAY;
              start_q   <= 1'b1;
              paddr_q   <= wr_addr_i;
              pdata_q   <= wr_data_i;
              stat_q    <= 1'b1;
              stat_b7_q <= wr_data_i[7];
            end
            default: seq_q <= SEQ_IDLE;
          endcase
        end
      end
    end
  end

  assign ident_o     = mode_q == RD_IDENT;
  assign stat_o      = stat_q;
  assign stat_b7_o   = stat_b7_q;
  assign pgm_start_o = start_q;
  assign pgm_addr_o  = paddr_q;
  assign pgm_data_o  = pdata_q;

  a_r4_bad_second_key: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_evt_i && !engaged && !hw_rst_i && seq_q == SEQ_UNL1 && wr_data_i != KEY_B)
      |=> (seq_q == SEQ_IDLE && mode_q == RD_ARRAY))
    else $error("R4 malformed unlock not rejected");

  a_r9_busy_holds_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (engaged && !hw_rst_i) |=> ($stable(seq_q) && $stable(mode_q)))
    else $error("R9 command accepted while busy");

  a_r8_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgm_start_o |=> !pgm_start_o)
    else $error("R8 start pulse longer than one clock");

  a_r11_reset_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_rst_i |=> (seq_q == SEQ_IDLE && mode_q == RD_ARRAY && !stat_q))
    else $error("R11 valid reset left state behind");

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int unsigned     AW       = 11,
  parameter int unsigned     RST_MIN  = 8,
  parameter int unsigned     SECTORS  = 4,
  parameter logic [SECTORS-1:0] PROT_MAP = 4'b0011,
  parameter logic [7:0]      MFR_CODE = 8'h3B,
  parameter logic [7:0]      DEV_CODE = 8'hD1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flash_rst_ni,
  input  logic          ce_ni,
  input  logic          oe_ni,
  input  logic          we_ni,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    data_i,
  output logic [7:0]    data_o,
  output logic          data_oe_o,
  input  logic          busy_i,
  output logic          pgm_start_o,
  output logic [AW-1:0] pgm_addr_o,
  output logic [7:0]    pgm_data_o,
  output logic          pgm_abort_o
);

  localparam int unsigned SEC_W = (SECTORS > 1) ? $clog2(SECTORS) : 1;

  logic          ce_q, oe_q, we_q;
  logic [AW-1:0] addr_q, wr_addr;
  logic [7:0]    wr_data, ram_rdata, id_byte, rd_byte;
  logic          wr_evt, blk, hw_rst;
  logic          ident, stat, stat_b7, rd_act;
  logic [SEC_W-1:0] sector;
  logic [7:0]    dout_q;
  logic          doe_q;

  fcc_bus_sampler #(.AW(AW)) i_sampler (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ce_ni    (ce_ni),
    .oe_ni    (oe_ni),
    .we_ni    (we_ni),
    .addr_i   (addr_i),
    .data_i   (data_i),
    .ce_q_o   (ce_q),
    .oe_q_o   (oe_q),
    .we_q_o   (we_q),
    .addr_q_o (addr_q),
    .wr_evt_o (wr_evt),
    .wr_addr_o(wr_addr),
    .wr_data_o(wr_data)
  );

  fcc_reset_filter #(.RST_MIN(RST_MIN)) i_rst_filt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flash_rst_ni(flash_rst_ni),
    .blk_o       (blk),
    .valid_o     (hw_rst)
  );

  fcc_cmd_fsm #(.AW(AW)) i_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hw_rst_i   (hw_rst),
    .wr_evt_i   (wr_evt && !blk),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .busy_i     (busy_i),
    .ident_o    (ident),
    .stat_o     (stat),
    .stat_b7_o  (stat_b7),
    .pgm_start_o(pgm_start_o),
    .pgm_addr_o (pgm_addr_o),
    .pgm_data_o (pgm_data_o)
  );

  fcc_array_ram #(.AW(AW)) i_ram (
    .clk_i  (clk_i),
    .we_i   (pgm_start_o),
    .waddr_i(pgm_addr_o),
    .wdata_i(pgm_data_o),
    .raddr_i(addr_q),
    .rdata_o(ram_rdata)
  );

  generate
    if (SECTORS > 1) begin : g_multi_sec
      assign sector = addr_q[AW-1 -: SEC_W];
    end else begin : g_single_sec
      assign sector = '0;
    end
  endgenerate

  always_comb begin
    unique case (addr_q[1:0])
      2'd0:    id_byte = MFR_CODE;
      2'd1:    id_byte = DEV_CODE;
      2'd2:    id_byte = {7'b0, PROT_MAP[sector]};
      default: id_byte = 8'h00;
    endcase
  end

  always_comb begin
    if (stat)       rd_byte = {~stat_b7, 7'b0};
    else if (ident) rd_byte = id_byte;
    else            rd_byte = ram_rdata;
  end

  assign rd_act = !ce_q && !oe_q && we_q && !blk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '0;
      doe_q  <= 1'b0;
    end else begin
      doe_q  <= rd_act;
      dout_q <= rd_act ? rd_byte : 8'h00;
    end
  end

  assign data_o      = dout_q;
  assign data_oe_o   = doe_q;
  assign pgm_abort_o = hw_rst;

  a_r10_oe_high_hiz: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |=> !data_oe_o)
    else $error("R10 driving with output enable high");

  a_r10_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_oe_o |-> data_o == 8'h00)
    else $error("R10 data present while not driven");

  a_r11_block_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blk |=> !data_oe_o)
    else $error("R11 driving during bus reset");

endmodule

// File: tb/test_flash_cmd_ctrl.sv
module test_flash_cmd_ctrl;

  localparam int unsigned AW = 11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          frst_n = 1'b1;
  logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdat = '0;
  logic [7:0]    dout;
  logic          doe;
  logic          busy = 1'b0;
  logic          pstart, pabort;
  logic [AW-1:0] paddr;
  logic [7:0]    pdata;

  int n_run = 0, n_fail = 0, cyc = 0;
  int n_start = 0, start_w = 0, n_abort = 0;
  logic [AW-1:0] last_paddr;
  logic [7:0]    last_pdata;

  always #2 clk = ~clk;

  flash_cmd_ctrl #(
    .AW(AW), .RST_MIN(4), .SECTORS(4), .PROT_MAP(4'b0101),
    .MFR_CODE(8'h5E), .DEV_CODE(8'hA7)
  ) i_flash_cmd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .flash_rst_ni(frst_n),
    .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .addr_i(addr), .data_i(wdat), .data_o(dout), .data_oe_o(doe),
    .busy_i(busy), .pgm_start_o(pstart), .pgm_addr_o(paddr),
    .pgm_data_o(pdata), .pgm_abort_o(pabort)
  );

  always @(negedge clk) begin
    if (pstart) begin
      n_start++;
      start_w++;
      last_paddr = paddr;
      last_pdata = pdata;
    end
    if (pabort) n_abort++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdat = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(2);
    we_n = 1'b1;
    idle(2);
    ce_n = 1'b1;
    idle(2);
  endtask

  task automatic bus_write_ce(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdat = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
    idle(2);
    ce_n = 1'b1;
    idle(2);
    we_n = 1'b1;
    idle(2);
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [7:0] d, output logic e);
    @(negedge clk);
    addr = a; we_n = 1'b1; ce_n = 1'b0; oe_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    d = dout; e = doe;
    oe_n = 1'b1; ce_n = 1'b1;
    idle(2);
  endtask

  task automatic expect_read(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    logic e;
    bus_read(a, d, e);
    check(e && d == exp, req, {e, d}, {1'b1, exp});
  endtask

  task automatic enter_ident();
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'h90);
  endtask

  task automatic start_program(input logic [AW-1:0] a, input logic [7:0] d);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h555, 8'hA0);
    bus_write(a, d);
  endtask

  task automatic program_done(input logic [AW-1:0] a, input logic [7:0] d);
    start_program(a, d);
    busy = 1'b1;
    idle(3);
    busy = 1'b0;
    idle(3);
  endtask

  task automatic t_reset_state();
    check(doe == 1'b0, "R1 no drive after reset", doe, 0);
    check(dout == 8'h00, "R10 quiet data after reset", dout, 0);
  endtask

  task automatic t_program_busy();
    int s0;
    s0 = n_start;
    start_w = 0;
    start_program(11'h100, 8'h3C);
    check(n_start == s0 + 1 && start_w == 1, "R8 single start pulse", start_w, 1);
    check(last_paddr == 11'h100, "R8 start address", last_paddr, 11'h100);
    check(last_pdata == 8'h3C, "R8 start data", last_pdata, 8'h3C);
    busy = 1'b1;
    expect_read(11'h100, 8'h80, "R9 status byte bit7 inverted (data bit7=0)");
    enter_ident();
    bus_write(11'h7FF, 8'hF0);
    busy = 1'b0;
    idle(3);
    expect_read(11'h100, 8'h3C, "R9 writes ignored while busy, R8 RAM stored");
    program_done(11'h000, 8'h11);
    expect_read(11'h000, 8'h11, "R1 array read needs no command");
  endtask

  task automatic t_ident();
    enter_ident();
    expect_read(11'h000, 8'h5E, "R5 manufacturer code");
    expect_read(11'h001, 8'hA7, "R5 device code");
    expect_read(11'h002, 8'h01, "R5 protect sector0");
    expect_read(11'h202, 8'h00, "R5 protect sector1");
    expect_read(11'h402, 8'h01, "R5 protect sector2");
    expect_read(11'h003, 8'h00, "R5 unused id slot");
    expect_read(11'h000, 8'h5E, "R6 mode persists over reads");
  endtask

  task automatic t_return_cmd();
    bus_write(11'h7FF, 8'hF0);
    expect_read(11'h000, 8'h11, "R7 F0 returns to array");
    enter_ident();
    bus_write(11'h555, 8'hAA);
    bus_write(11'h123, 8'hF0);
    expect_read(11'h000, 8'h11, "R7 F0 mid-sequence");
  endtask

  task automatic t_malformed();
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AB, 8'h55);
    bus_write(11'h555, 8'h90);
    expect_read(11'h000, 8'h11, "R4 wrong second address");
    enter_ident();
    bus_write(11'h555, 8'h12);
    expect_read(11'h000, 8'h11, "R4 wrong first data exits ident");
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    bus_write(11'h554, 8'h90);
    expect_read(11'h000, 8'h11, "R4 wrong select address");
  endtask

  task automatic t_ce_edge_write();
    bus_write_ce(11'h555, 8'hAA);
    bus_write_ce(11'h2AA, 8'h55);
    bus_write_ce(11'h555, 8'h90);
    expect_read(11'h000, 8'h5E, "R3 write ended by chip-enable");
    bus_write(11'h000, 8'hF0);
  endtask

  task automatic t_bus_conditions();
    @(negedge clk);
    addr = 11'h000; ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    idle(4);
    check(doe == 1'b0 && dout == 8'h00, "R10 oe high not driven", {doe, dout}, 0);
    oe_n = 1'b0; we_n = 1'b0;
    idle(4);
    check(doe == 1'b0, "R2 we low blocks read", doe, 0);
    ce_n = 1'b1; we_n = 1'b1;
    idle(4);
    check(doe == 1'b0, "R2 ce high blocks read", doe, 0);
    oe_n = 1'b1;
    idle(2);
    bus_write(11'h555, 8'hAA);
    bus_write(11'h2AA, 8'h55);
    @(negedge clk);
    addr = 11'h555; wdat = 8'h90; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
    idle(2);
    we_n = 1'b1; oe_n = 1'b1;
    idle(1);
    ce_n = 1'b1;
    idle(2);
    expect_read(11'h000, 8'h11, "R3 oe low phase is not a write");
    bus_write(11'h000, 8'hF0);
  endtask

  task automatic t_reset_glitch();
    int a0;
    enter_ident();
    a0 = n_abort;
    @(negedge clk);
    frst_n = 1'b0;
    idle(2);
    frst_n = 1'b1;
    idle(3);
    check(n_abort == a0, "R12 glitch gives no abort", n_abort, a0);
    expect_read(11'h000, 8'h5E, "R12 glitch keeps ident mode");
  endtask

  task automatic t_reset_valid();
    int a0;
    logic [7:0] d;
    logic e;
    a0 = n_abort;
    @(negedge clk);
    frst_n = 1'b0;
    addr = 11'h000; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(doe == 1'b0, "R11 no drive during reset", doe, 0);
    ce_n = 1'b1; oe_n = 1'b1;
    idle(4);
    frst_n = 1'b1;
    idle(3);
    check(n_abort == a0 + 1, "R11 one abort pulse", n_abort, a0 + 1);
    bus_read(11'h000, d, e);
    check(e && d == 8'h11, "R11 R1 array mode after reset", {e, d}, 9'h111);
  endtask

  task automatic t_reset_mid_program();
    start_program(11'h010, 8'h80);
    busy = 1'b1;
    expect_read(11'h010, 8'h00, "R9 status byte bit7 inverted (data bit7=1)");
    @(negedge clk);
    frst_n = 1'b0;
    idle(2);
    busy = 1'b0;
    idle(5);
    frst_n = 1'b1;
    idle(3);
    expect_read(11'h010, 8'h80, "R11 reset clears busy status");
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    t_reset_state();
    t_program_busy();
    t_ident();
    t_return_cmd();
    t_malformed();
    t_ce_edge_write();
    t_bus_conditions();
    t_reset_glitch();
    t_reset_valid();
    t_reset_mid_program();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule